// File: doc/BRIEF.md
# Auxiliary ADC Channel Sequencer

This block runs one auxiliary conversion round each time the host asks for it. It never converts on its own. The host first writes a channel-enable mask over a byte-wide register bus. A separate write then sets the go bit. The sequencer takes a copy of the mask and visits every enabled channel once, in ascending channel order. For each channel it drives a one-cycle start request and the channel index to an external converter, then waits for a done pulse that carries a signed two's-complement code. Each code is stored in that channel's result register. Two flags report progress: `busy` is high while conversions are outstanding, and `drdy` rises one cycle after the last result has been written.

A go write clears `drdy` and loads every enabled channel's result with the most-negative code (0x8000 for 16-bit results). A host that reads a result before its conversion has finished therefore gets an obvious diagnostic value. A go write during a round aborts it: the outstanding conversion is dropped, an abort pulse goes to the converter, and the round starts again from the lowest enabled channel. Results are read one byte at a time. Reading the high byte of a channel copies its lower bytes into a snapshot, so the later byte reads belong to the same conversion even if the sequencer overwrites the live register in the meantime.

Top module: `aux_conv_sequencer`

## Requirements
- R1: After reset `busy` and `drdy` are low, `cnv_start` is low, and every result register holds the sentinel (most-negative code, 0x8000).
- R2: A write to the enable register (address 0x00, bit n enables channel n) starts no conversion: `cnv_start` and `busy` stay low.
- R3: A go write (address 0x01, data bit 0 = 1) with a non-zero enable mask makes `busy` high and `drdy` low in the next cycle. In that same cycle `cnv_start` is high, and `cnv_ch` names the lowest enabled channel.
- R4: A round visits each enabled channel exactly once, in ascending index order, and skips disabled channels. The `cnv_result` value present with `cnv_done` is stored unchanged in that channel's result register.
- R5: `busy` falls in the cycle after the final `cnv_done` is accepted, and `drdy` rises exactly one cycle after that.
- R6: A go write sets the result of every enabled channel to the sentinel and leaves the results of disabled channels unchanged.
- R7: A go write while `busy` is high pulses `cnv_abort` in that cycle and ignores any `cnv_done` in that cycle. The round then restarts from the lowest enabled channel, and every enabled channel is converted again.
- R8: A go write with an all-zero mask sets `drdy` in the next cycle and never raises `busy` or `cnv_start`.
- R9: Reading a result's high byte freezes its lower byte(s). A later low-byte read returns the value from the time of the high-byte read, even if the live result has changed since.
- R10: The freeze is released by any low-byte read or moved by a high-byte read of a different channel. After release, a low-byte read returns the live value.
- R11: Address map: status at 0x02 (bit 0 busy, bit 1 data ready), enable mask readable at 0x00, and channel c's result byte k at 0x10 + 4*c + k, where byte 0 is the least significant byte and byte RES_W/8-1 is the high byte.
- R12: `cnv_start` is a single-cycle pulse per conversion and is only ever issued while a round is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (locks and releases snapshots) |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| cnv_start | output | 1 | Start one conversion on `cnv_ch` |
| cnv_ch | output | IDX_W | Channel being converted |
| cnv_abort | output | 1 | Outstanding conversion is cancelled |
| cnv_done | input | 1 | Conversion finished, `cnv_result` valid |
| cnv_result | input | RES_W | Two's-complement conversion code |
| busy | output | 1 | Round in progress |
| drdy | output | 1 | All results of the last round are stored |

## Verification
The hardest state to reach is a restart that lands while a conversion is partly complete. In that state the converter's done pulse may already be on its way, the byte snapshot may refer to a value the restart is about to overwrite, and the expected visit order has to be thrown away in the middle. The bench reaches it with a converter model whose latency varies randomly from conversion to conversion. It issues a go write a fixed number of cycles into a full-mask round and makes the scoreboard discard its queue at that same cycle. It also locks a snapshot on one round's value and reads the low byte back after a later round has rewritten the live register.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2,
      ST_FIN   = 2'd3
   } seq_state_e;

   localparam logic [7:0] REG_ENABLE      = 8'h00;
   localparam logic [7:0] REG_CMD         = 8'h01;
   localparam logic [7:0] REG_STATUS      = 8'h02;
   localparam logic [7:0] REG_RESULT_BASE = 8'h10;

endpackage

// File: rtl/aux_seq_pick.sv
// Finds the lowest set bit of a mask at or above a starting index.
module aux_seq_pick #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 3
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [IDX_W:0]    from,
   output logic              found,
   output logic [IDX_W-1:0]  idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i] && (i >= int'(from))) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/aux_seq_ctrl.sv
// Round sequencer: issue, wait, advance, finish; restart on go.
module aux_seq_ctrl import aux_seq_pkg::*; #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [NUM_CH-1:0] mask,
   input  logic              cnv_done,
   output logic              busy,
   output logic              drdy,
   output logic              cnv_start,
   output logic [IDX_W-1:0]  cnv_ch,
   output logic              cnv_abort,
   output logic              res_we
);

   seq_state_e        state_q;
   logic [IDX_W-1:0]  cur_q;
   logic [NUM_CH-1:0] rmask_q;
   logic              drdy_q;

   logic              first_found, next_found;
   logic [IDX_W-1:0]  first_idx, next_idx;

   aux_seq_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_first (
      .mask  (mask),
      .from  ('0),
      .found (first_found),
      .idx   (first_idx)
   );

   aux_seq_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_next (
      .mask  (rmask_q),
      .from  ({1'b0, cur_q} + (IDX_W+1)'(1)),
      .found (next_found),
      .idx   (next_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         rmask_q <= '0;
         drdy_q  <= 1'b0;
      end else if (go) begin
         rmask_q <= mask;
         if (first_found) begin
            cur_q   <= first_idx;
            state_q <= ST_ISSUE;
            drdy_q  <= 1'b0;
         end else begin
            state_q <= ST_IDLE;
            drdy_q  <= 1'b1;
         end
      end else begin
         unique case (state_q)
            ST_ISSUE: state_q <= ST_WAIT;
            ST_WAIT: begin
               if (cnv_done) begin
                  if (next_found) begin
                     cur_q   <= next_idx;
                     state_q <= ST_ISSUE;
                  end else begin
                     state_q <= ST_FIN;
                  end
               end
            end
            ST_FIN: begin
               drdy_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
   assign drdy      = drdy_q;
   assign cnv_start = (state_q == ST_ISSUE);
   assign cnv_ch    = cur_q;
   assign cnv_abort = go && busy;
   assign res_we    = (state_q == ST_WAIT) && cnv_done && !go;

endmodule

// File: rtl/aux_seq_results.sv
// Per-channel result registers with sentinel clear and a byte-read snapshot.
module aux_seq_results #(
   parameter int NUM_CH = 8,
   parameter int IDX_W  = 3,
   parameter int RES_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_we,
   input  logic [IDX_W-1:0]  res_wch,
   input  logic [RES_W-1:0]  res_wdata,
   input  logic              clr,
   input  logic [NUM_CH-1:0] clr_mask,
   input  logic              rd_en,
   input  logic              rd_ok,
   input  logic [IDX_W-1:0]  rd_ch,
   input  logic [1:0]        rd_byte,
   output logic [7:0]        rd_data
);

   localparam int NBYTES = RES_W / 8;
   localparam int HI     = NBYTES - 1;
   localparam int LOW_W  = RES_W - 8;
   localparam logic [RES_W-1:0] SENTINEL = {1'b1, {(RES_W-1){1'b0}}};

   logic [RES_W-1:0] res_q [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_res
      always_ff @(posedge clk) begin
         if (!rst_n)
            res_q[c] <= SENTINEL;
         else if (clr && clr_mask[c])
            res_q[c] <= SENTINEL;
         else if (res_we && (res_wch == IDX_W'(c)))
            res_q[c] <= res_wdata;
      end
   end

   logic             lock_v_q;
   logic [IDX_W-1:0] lock_ch_q;
   logic [LOW_W-1:0] snap_q;
   logic             rd_hi, rd_lo;

   assign rd_hi = rd_ok && (int'(rd_byte) == HI);
   assign rd_lo = rd_ok && (rd_byte == 2'd0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_v_q  <= 1'b0;
         lock_ch_q <= '0;
         snap_q    <= '0;
      end else if (rd_en && rd_hi) begin
         lock_v_q  <= 1'b1;
         lock_ch_q <= rd_ch;
         snap_q    <= res_q[rd_ch][LOW_W-1:0];
      end else if (rd_en && rd_lo) begin
         lock_v_q  <= 1'b0;
      end
   end

   logic [RES_W-1:0] word, shifted;
   logic             use_snap;

   always_comb begin
      use_snap = lock_v_q && (lock_ch_q == rd_ch) && (int'(rd_byte) < HI);
      word     = use_snap ? {8'h00, snap_q} : res_q[rd_ch];
      shifted  = word >> {rd_byte, 3'b000};
      rd_data  = rd_ok ? shifted[7:0] : 8'h00;
   end

endmodule

// File: rtl/aux_conv_sequencer.sv
module aux_conv_sequencer import aux_seq_pkg::*; #(
   parameter int NUM_CH = 8,
   parameter int RES_W  = 16,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_addr,
   input  logic [7:0]       wr_data,
   input  logic             rd_en,
   input  logic [7:0]       rd_addr,
   output logic [7:0]       rd_data,
   output logic             cnv_start,
   output logic [IDX_W-1:0] cnv_ch,
   output logic             cnv_abort,
   input  logic             cnv_done,
   input  logic [RES_W-1:0] cnv_result,
   output logic             busy,
   output logic             drdy
);

   localparam int HI = RES_W / 8 - 1;

   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("NUM_CH must lie in 1..8 (one enable byte)");
   end
   if (RES_W != 16 && RES_W != 24) begin : g_bad_w
      $error("RES_W must be 16 or 24");
   end

   logic [NUM_CH-1:0] en_q;
   logic              go;
   logic              res_we;

   assign go = wr_en && (wr_addr == REG_CMD) && wr_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr_en && (wr_addr == REG_ENABLE))
         en_q <= wr_data[NUM_CH-1:0];
   end

   aux_seq_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .mask      (en_q),
      .cnv_done  (cnv_done),
      .busy      (busy),
      .drdy      (drdy),
      .cnv_start (cnv_start),
      .cnv_ch    (cnv_ch),
      .cnv_abort (cnv_abort),
      .res_we    (res_we)
   );

   logic [7:0]       off;
   logic [5:0]       slot;
   logic [1:0]       bsel;
   logic             rd_ok;
   logic [IDX_W-1:0] rd_ch;
   logic [7:0]       res_byte;

   assign off   = rd_addr - REG_RESULT_BASE;
   assign slot  = off[7:2];
   assign bsel  = off[1:0];
   assign rd_ok = (rd_addr >= REG_RESULT_BASE) && (int'(slot) < NUM_CH) && (int'(bsel) <= HI);
   assign rd_ch = slot[IDX_W-1:0];

   aux_seq_results #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .RES_W(RES_W)) u_res (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_we    (res_we),
      .res_wch   (cnv_ch),
      .res_wdata (cnv_result),
      .clr       (go),
      .clr_mask  (en_q),
      .rd_en     (rd_en),
      .rd_ok     (rd_ok),
      .rd_ch     (rd_ch),
      .rd_byte   (bsel),
      .rd_data   (res_byte)
   );

   always_comb begin
      if (rd_addr == REG_ENABLE)
         rd_data = 8'(en_q);
      else if (rd_addr == REG_STATUS)
         rd_data = {6'b0, drdy, busy};
      else
         rd_data = res_byte;
   end

endmodule

// File: rtl/aux_conv_sequencer_chk.sv
module aux_conv_sequencer_chk import aux_seq_pkg::*; #(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [7:0]        wr_addr,
   input logic [7:0]        wr_data,
   input logic [NUM_CH-1:0] en_q,
   input logic              busy,
   input logic              drdy,
   input logic              cnv_start,
   input logic              cnv_abort
);

   logic go_w;
   assign go_w = wr_en && (wr_addr == REG_CMD) && wr_data[0];

   // R5
   busy_drdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && drdy));

   // R3
   go_starts_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_w && (en_q != '0) |=> busy && !drdy && cnv_start);

   // R8
   empty_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_w && (en_q == '0) |=> drdy && !busy && !cnv_start);

   // R5
   fin_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && !go_w |=> drdy);

   // R7
   abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_abort && (en_q != '0) |=> cnv_start);

   // R12
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnv_start && !go_w |=> !cnv_start);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !go_w |=> !cnv_start);

endmodule

bind aux_conv_sequencer aux_conv_sequencer_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .en_q      (en_q),
   .busy      (busy),
   .drdy      (drdy),
   .cnv_start (cnv_start),
   .cnv_abort (cnv_abort)
);

// File: tb/aux_conv_sequencer_bench.sv
module aux_conv_sequencer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH     = 8;
   localparam int RES_W      = 16;
   localparam int IDX_W      = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [7:0]       wr_addr = '0;
   logic [7:0]       wr_data = '0;
   logic             rd_en = 1'b0;
   logic [7:0]       rd_addr = '0;
   logic [7:0]       rd_data;
   logic             cnv_start;
   logic [IDX_W-1:0] cnv_ch;
   logic             cnv_abort;
   logic             cnv_done = 1'b0;
   logic [RES_W-1:0] cnv_result = '0;
   logic             busy;
   logic             drdy;

   aux_conv_sequencer #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_aux_conv_sequencer (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // scoreboard state
   int              exp_q[$];
   int              starts = 0;
   int              aborts = 0;
   logic [RES_W-1:0] exp_res [NUM_CH];
   int              serial = 0;

   function automatic void push_round(logic [7:0] mask);
      exp_q.delete();
      starts = 0;
      for (int c = 0; c < NUM_CH; c++)
         if (mask[c]) exp_q.push_back(c);
   endfunction

   // monitor: pops expected channel on each observed start (R3, R4)
   always @(negedge clk) begin
      if (rst_n && cnv_start) begin
         starts++;
         if (exp_q.size() == 0) begin
            checks++; failures++;
            $display("FAIL R4 actual=%0d expected=none (unexpected start)", cnv_ch);
         end else begin
            check("R4 visit order", int'(cnv_ch), exp_q.pop_front());
         end
      end
      if (rst_n && cnv_abort) aborts++;
   end

   // converter model with random latency
   bit pend = 0;
   int pend_cnt = 0;
   int pch = 0;
   always @(negedge clk) begin
      bit go_now;
      go_now = wr_en && (wr_addr == 8'h01) && wr_data[0];
      cnv_done = 1'b0;
      if (cnv_abort) pend = 0;
      if (cnv_start) begin
         pend = 1;
         pch = int'(cnv_ch);
         pend_cnt = 1 + int'($urandom % 4);
      end else if (pend) begin
         pend_cnt--;
         if (pend_cnt == 0) begin
            serial++;
            cnv_done = 1'b1;
            cnv_result = {8'($urandom), 8'(serial)};
            pend = 0;
            if (!go_now) exp_res[pch] = cnv_result;
         end
      end
   end

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic go_round(logic [7:0] mask);
      wr(8'h01, 8'h01);
      push_round(mask);
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] d);
      @(posedge clk); #1;
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      d = rd_data;
      @(posedge clk); #1;
      rd_en = 1'b0;
   endtask

   function automatic logic [7:0] res_addr(int ch, int b);
      return 8'(8'h10 + 4*ch + b);
   endfunction

   // waits for the end of a round and checks busy/drdy timing (R5)
   task automatic wait_round();
      bit prev_busy = 1;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (prev_busy && !busy) begin
            check("R5 drdy low as busy falls", int'(drdy), 0);
            @(negedge clk);
            check("R5 drdy one cycle later", int'(drdy), 1);
            return;
         end
         prev_busy = busy;
      end
      checks++; failures++;
      $display("FAIL R5 actual=busy stuck expected=round end");
   endtask

   task automatic check_results(logic [7:0] mask, string req);
      logic [7:0] d;
      for (int c = 0; c < NUM_CH; c++) begin
         if (mask[c]) begin
            rd(res_addr(c, 1), d);
            check(req, int'(d), int'(exp_res[c][15:8]));
            rd(res_addr(c, 0), d);
            check(req, int'(d), int'(exp_res[c][7:0]));
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      logic [RES_W-1:0] v1;
      for (int c = 0; c < NUM_CH; c++) exp_res[c] = 16'h8000;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 busy", int'(busy), 0);
      check("R1 drdy", int'(drdy), 0);
      check("R1 start", int'(cnv_start), 0);
      rd(res_addr(5, 1), d);
      check("R1 sentinel high", int'(d), 8'h80);
      rd(res_addr(5, 0), d);
      check("R1 sentinel low", int'(d), 8'h00);
      rd(8'h02, d);
      check("R11 status after reset", int'(d), 0);

      // R2 enable write alone
      wr(8'h00, 8'hA5);
      repeat (8) @(negedge clk);
      check("R2 no start", starts, 0);
      check("R2 busy low", int'(busy), 0);
      rd(8'h00, d);
      check("R11 enable readback", int'(d), 8'hA5);

      // R3 R4 first round
      go_round(8'hA5);
      check("R3 busy next cycle", int'(busy), 1);
      check("R3 drdy cleared", int'(drdy), 0);
      check("R3 start now", int'(cnv_start), 1);
      check("R3 first channel", int'(cnv_ch), 0);
      rd(8'h02, d);
      check("R11 status busy", int'(d), 8'h01);
      wait_round();
      check("R4 all visited", starts, 4);
      check("R4 queue drained", exp_q.size(), 0);
      rd(8'h02, d);
      check("R11 status ready", int'(d), 8'h02);
      check_results(8'hA5, "R4 stored result");

      // R6 sentinel on enabled, disabled kept
      wr(8'h00, 8'h0F);
      go_round(8'h0F);
      rd(res_addr(0, 1), d);
      check("R6 enabled sentinel", int'(d), 8'h80);
      rd(res_addr(7, 0), d);
      check("R6 disabled kept", int'(d), int'(exp_res[7][7:0]));
      wait_round();
      check_results(8'h0F, "R4 second pattern");

      // R7 abort mid-round
      wr(8'h00, 8'hFF);
      go_round(8'hFF);
      repeat (6) @(posedge clk);
      aborts = 0;
      go_round(8'hFF);
      check("R7 abort pulse", aborts, 1);
      check("R7 restart busy", int'(busy), 1);
      check("R7 restart channel", int'(cnv_ch), 0);
      wait_round();
      check("R7 full round after restart", starts, 8);
      check("R7 queue drained", exp_q.size(), 0);
      check_results(8'hFF, "R7 results after restart");

      // R8 zero-mask go
      wr(8'h00, 8'h00);
      go_round(8'h00);
      check("R8 drdy", int'(drdy), 1);
      check("R8 busy", int'(busy), 0);
      repeat (6) @(negedge clk);
      check("R8 no start", starts, 0);

      // R9 snapshot across a rewrite
      wr(8'h00, 8'h04);
      v1 = exp_res[2];
      rd(res_addr(2, 1), d);
      check("R9 high byte", int'(d), int'(v1[15:8]));
      go_round(8'h04);
      wait_round();
      rd(res_addr(2, 0), d);
      check("R9 low from snapshot", int'(d), int'(v1[7:0]));
      // R10 released by the low read
      rd(res_addr(2, 0), d);
      check("R10 live after low read", int'(d), int'(exp_res[2][7:0]));
      // R10 moved by another channel's high read
      v1 = exp_res[2];
      rd(res_addr(2, 1), d);
      go_round(8'h04);
      wait_round();
      rd(res_addr(3, 1), d);
      check("R10 other channel high", int'(d), int'(exp_res[3][15:8]));
      rd(res_addr(2, 0), d);
      check("R10 live after move", int'(d), int'(exp_res[2][7:0]));

      finish_run();
   end

endmodule